// File: doc/BRIEF.md
# Transfer Descriptor Status Writeback

This block produces the rewritten status field of a USB host transfer descriptor once the transaction that descriptor described has finished. It takes the status the descriptor held before the attempt, the outcome class reported by the transaction engine, the number of bytes received and the endpoint's maximum packet size. From these it returns three things: the status word to store back, a flag that closes the current transfer set, and one-cycle-per-result event flags. An interrupt aggregator latches those event flags and reports them at frame end.

Handling depends on the outcome class. A STALL handshake or a babbling device retires the descriptor at once and leaves the retry countdown untouched. Buffer overrun or underrun, bit-stuff errors and CRC or timeout failures each use up one retry. The descriptor retires only when the countdown runs out. A countdown that starts at zero never runs out. Transactions enter through a valid/ready handshake. One result is held in an output register until the consumer takes it.

Top module: `td_status_wb`

## Requirements
- R1: The status word is 7 bits: bit 6 active, bit 5 stalled, bit 4 babble, bits 3:2 retry countdown, bit 1 interrupt-on-completion flag, bit 0 short-packet flag. After reset `out_valid` is 0. An accepted transaction (`in_valid` and `in_ready` high at a clock edge) shows its result with `out_valid` high after that edge. `in_ready` is high whenever no result is held or `out_ready` is high. A held result and `out_valid` stay unchanged while `out_ready` is low.
- R2: On outcome code 0 (success) for an active descriptor, active is cleared and stalled, babble and the countdown keep their values.
- R3: On success, `set_done` is raised when the transfer kind is control (0), bulk (1) or interrupt (2), `dir_in` is 1 and `rx_len` is below `max_pkt`. `ev_short` is raised in that case only if status bit 0 is set. Isochronous (3), OUT transfers and full-size packets raise neither.
- R4: On outcome code 1 (STALL handshake), active is cleared, stalled is set, the countdown is unchanged and `ev_error` is raised.
- R5: On outcome code 2 (babble), active is cleared, stalled and babble are both set, the countdown is unchanged and `ev_error` is raised.
- R6: Outcome codes 3 (buffer overrun/underrun), 4 (bit-stuff), 5 (CRC/timeout) and the unused codes 6 and 7 each reduce a nonzero countdown by one. If the new count is nonzero, active stays set and no event is raised.
- R7: When such a reduction brings the countdown to zero, active is cleared, stalled is set and `ev_error` is raised.
- R8: A countdown of zero on entry means unlimited retries: outcome codes 3 to 7 return the status word unchanged and raise no event.
- R9: `ev_ioc` is raised exactly when the returned status has bit 1 set and bit 6 (active) clear. This covers success, error retirement and a descriptor that was already inactive.
- R10: A descriptor that enters with active clear is returned unchanged, and neither `set_done`, `ev_short` nor `ev_error` is raised, whatever the outcome.
- R11: `set_done`, `ev_ioc`, `ev_short` and `ev_error` are low whenever `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A finished transaction is presented |
| in_ready | output | 1 | The block can take a transaction this cycle |
| td_stat | input | 7 | Descriptor status before the transaction |
| xfer_kind | input | 2 | 0 control, 1 bulk, 2 interrupt, 3 isochronous |
| dir_in | input | 1 | 1 for an IN (device-to-host) transaction |
| result_code | input | 3 | Transaction outcome class |
| rx_len | input | LEN_W | Bytes received |
| max_pkt | input | LEN_W | Endpoint maximum packet size |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | Consumer takes the held result |
| td_stat_new | output | 7 | Status word to write back |
| set_done | output | 1 | Transfer set ends (short packet) |
| ev_ioc | output | 1 | Completion interrupt event |
| ev_short | output | 1 | Short-packet interrupt event |
| ev_error | output | 1 | Error interrupt event |

## Verification
Several properties are checked on every cycle. The output register holds a result steady while the consumer stalls. Event flags stay low when no result is held. A short-packet event never appears without the transfer-set flag. For stall, babble, countdown reduction, exhaustion, unlimited retry and inactive entries, each accepted transaction is tied to the status returned one cycle later. Only the bench scenarios show the short-packet decision across transfer kinds, directions and lengths at and around the maximum packet size, the full mix of flag combinations under random stimulus, and correct flow of results when the consumer pauses and resumes.

// File: rtl/td_wb_pkg.sv
package td_wb_pkg;
  localparam int ST_W = 7;

  typedef enum logic [2:0] {
    OC_OK     = 3'd0,
    OC_STALL  = 3'd1,
    OC_BABBLE = 3'd2,
    OC_BUF    = 3'd3,
    OC_STUFF  = 3'd4,
    OC_CRC    = 3'd5,
    OC_RSV6   = 3'd6,
    OC_RSV7   = 3'd7
  } outcome_e;

  typedef enum logic [1:0] {
    XK_CTRL = 2'd0,
    XK_BULK = 2'd1,
    XK_INTR = 2'd2,
    XK_ISO  = 2'd3
  } xfer_e;

  typedef struct packed {
    logic       active;
    logic       stalled;
    logic       babble;
    logic [1:0] errcnt;
    logic       ioc;
    logic       spd;
  } td_stat_t;

  // Outcomes that spend one retry instead of retiring immediately.
  function automatic logic f_counted(input logic [2:0] oc);
    return oc >= 3'd3;
  endfunction

  // Countdown step; zero means unlimited and is never moved.
  function automatic logic [1:0] f_cnt_step(input logic [1:0] c);
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction
endpackage

// File: rtl/td_err_ctr.sv
module td_err_ctr
  import td_wb_pkg::*;
(
  input  logic       counted,
  input  logic [1:0] cnt_cur,
  output logic [1:0] cnt_nxt,
  output logic       exhausted
);
  always_comb begin
    cnt_nxt   = counted ? f_cnt_step(cnt_cur) : cnt_cur;
    exhausted = counted && (cnt_cur == 2'd1);
  end
endmodule

// File: rtl/td_short_det.sv
module td_short_det
  import td_wb_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic [1:0]       xfer_kind,
  input  logic             dir_in,
  input  logic [LEN_W-1:0] rx_len,
  input  logic [LEN_W-1:0] max_pkt,
  output logic             is_short
);
  logic kind_ok;
  always_comb begin
    kind_ok  = (xfer_e'(xfer_kind) != XK_ISO);
    is_short = kind_ok && dir_in && (rx_len < max_pkt);
  end
endmodule

// File: rtl/td_status_calc.sv
module td_status_calc
  import td_wb_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic [ST_W-1:0]  stat_cur,
  input  logic [1:0]       xfer_kind,
  input  logic             dir_in,
  input  logic [2:0]       result_code,
  input  logic [LEN_W-1:0] rx_len,
  input  logic [LEN_W-1:0] max_pkt,
  output logic [ST_W-1:0]  stat_nxt,
  output logic             done,
  output logic             ioc,
  output logic             shrt,
  output logic             err,
  output logic             exhausted,
  output logic             short_raw
);
  td_stat_t   cur, nxt;
  logic       counted;
  logic [1:0] cnt_nxt;

  assign cur     = td_stat_t'(stat_cur);
  assign counted = cur.active && f_counted(result_code);

  td_err_ctr u_ctr (
    .counted   (counted),
    .cnt_cur   (cur.errcnt),
    .cnt_nxt   (cnt_nxt),
    .exhausted (exhausted)
  );

  td_short_det #(.LEN_W(LEN_W)) u_short (
    .xfer_kind (xfer_kind),
    .dir_in    (dir_in),
    .rx_len    (rx_len),
    .max_pkt   (max_pkt),
    .is_short  (short_raw)
  );

  always_comb begin
    nxt  = cur;
    done = 1'b0;
    shrt = 1'b0;
    err  = 1'b0;
    if (cur.active) begin
      case (outcome_e'(result_code))
        OC_OK: begin
          nxt.active = 1'b0;
          done       = short_raw;
          shrt       = short_raw && cur.spd;
        end
        OC_STALL: begin
          nxt.active  = 1'b0;
          nxt.stalled = 1'b1;
          err         = 1'b1;
        end
        OC_BABBLE: begin
          nxt.active  = 1'b0;
          nxt.stalled = 1'b1;
          nxt.babble  = 1'b1;
          err         = 1'b1;
        end
        default: begin
          nxt.errcnt = cnt_nxt;
          if (exhausted) begin
            nxt.active  = 1'b0;
            nxt.stalled = 1'b1;
            err         = 1'b1;
          end
        end
      endcase
    end
    ioc = nxt.ioc && !nxt.active;
  end

  assign stat_nxt = nxt;
endmodule

// File: rtl/td_status_wb.sv
module td_status_wb
  import td_wb_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [6:0]       td_stat,
  input  logic [1:0]       xfer_kind,
  input  logic             dir_in,
  input  logic [2:0]       result_code,
  input  logic [LEN_W-1:0] rx_len,
  input  logic [LEN_W-1:0] max_pkt,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [6:0]       td_stat_new,
  output logic             set_done,
  output logic             ev_ioc,
  output logic             ev_short,
  output logic             ev_error
);
  logic [ST_W-1:0] c_stat;
  logic            c_done, c_ioc, c_short, c_err;
  logic            w_exhausted, w_short_raw, w_fire;

  assign in_ready = !out_valid || out_ready;
  assign w_fire   = in_valid && in_ready;

  td_status_calc #(.LEN_W(LEN_W)) u_calc (
    .stat_cur    (td_stat),
    .xfer_kind   (xfer_kind),
    .dir_in      (dir_in),
    .result_code (result_code),
    .rx_len      (rx_len),
    .max_pkt     (max_pkt),
    .stat_nxt    (c_stat),
    .done        (c_done),
    .ioc         (c_ioc),
    .shrt        (c_short),
    .err         (c_err),
    .exhausted   (w_exhausted),
    .short_raw   (w_short_raw)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      td_stat_new <= '0;
      set_done    <= 1'b0;
      ev_ioc      <= 1'b0;
      ev_short    <= 1'b0;
      ev_error    <= 1'b0;
    end else if (w_fire) begin
      out_valid   <= 1'b1;
      td_stat_new <= c_stat;
      set_done    <= c_done;
      ev_ioc      <= c_ioc;
      ev_short    <= c_short;
      ev_error    <= c_err;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
      set_done    <= 1'b0;
      ev_ioc      <= 1'b0;
      ev_short    <= 1'b0;
      ev_error    <= 1'b0;
    end
  end
endmodule

// File: rtl/td_status_wb_chk.sv
module td_status_wb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [6:0] td_stat,
  input logic [2:0] result_code,
  input logic       out_valid,
  input logic       out_ready,
  input logic [6:0] td_stat_new,
  input logic       set_done,
  input logic       ev_ioc,
  input logic       ev_short,
  input logic       ev_error,
  input logic       w_exhausted,
  input logic       w_short_raw
);
  logic fire;
  assign fire = in_valid && in_ready;

  a_r1_result_next: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(td_stat_new)));

  a_r4_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && td_stat[6] && result_code == 3'd1) |=>
      (td_stat_new[6:5] == 2'b01 && td_stat_new[3:2] == $past(td_stat[3:2]) && ev_error));

  a_r5_babble: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && td_stat[6] && result_code == 3'd2) |=>
      (td_stat_new[6:4] == 3'b011 && td_stat_new[3:2] == $past(td_stat[3:2]) && ev_error));

  a_r6_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && td_stat[6] && result_code >= 3'd3 && td_stat[3:2] > 2'd1) |=>
      (td_stat_new[6] && td_stat_new[3:2] == $past(td_stat[3:2]) - 2'd1 && !ev_error));

  a_r7_exhaust: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && w_exhausted) |=>
      (!td_stat_new[6] && td_stat_new[5] && td_stat_new[3:2] == 2'd0 && ev_error));

  a_r8_unlimited: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && td_stat[6] && result_code >= 3'd3 && td_stat[3:2] == 2'd0) |=>
      (td_stat_new == $past(td_stat) && !ev_error && !ev_ioc));

  a_r9_ioc: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (ev_ioc == (td_stat_new[1] && !td_stat_new[6])));

  a_r10_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !td_stat[6]) |=>
      (td_stat_new == $past(td_stat) && !ev_error && !set_done && !ev_short));

  a_r3_spd: assert property (@(posedge clk) disable iff (!rst_n)
    ev_short |-> (set_done && td_stat_new[0]));

  a_r3_short_src: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && td_stat[6] && result_code == 3'd0 && !w_short_raw) |=> !set_done);

  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(set_done || ev_ioc || ev_short || ev_error));
endmodule

bind td_status_wb td_status_wb_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .td_stat     (td_stat),
  .result_code (result_code),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .td_stat_new (td_stat_new),
  .set_done    (set_done),
  .ev_ioc      (ev_ioc),
  .ev_short    (ev_short),
  .ev_error    (ev_error),
  .w_exhausted (w_exhausted),
  .w_short_raw (w_short_raw)
);

// File: tb/td_status_wb_bench.sv
module td_status_wb_bench;
  localparam int LW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [6:0]    td_stat = '0;
  logic [1:0]    xfer_kind = '0;
  logic          dir_in = 1'b0;
  logic [2:0]    result_code = '0;
  logic [LW-1:0] rx_len = '0;
  logic [LW-1:0] max_pkt = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [6:0]    td_stat_new;
  logic          set_done, ev_ioc, ev_short, ev_error;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  td_status_wb #(.LEN_W(LW)) u_td_status_wb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .td_stat(td_stat), .xfer_kind(xfer_kind), .dir_in(dir_in),
    .result_code(result_code), .rx_len(rx_len), .max_pkt(max_pkt),
    .out_valid(out_valid), .out_ready(out_ready), .td_stat_new(td_stat_new),
    .set_done(set_done), .ev_ioc(ev_ioc), .ev_short(ev_short), .ev_error(ev_error)
  );

  // Reference: {status[6:0], done, ioc, short, error}
  function automatic logic [10:0] model(input logic [6:0] s, input logic [1:0] k,
      input logic d, input logic [2:0] oc, input logic [LW-1:0] rx, input logic [LW-1:0] mp);
    logic a, st, bb, io, sp, dn, es, ee;
    logic [1:0] c;
    {a, st, bb, c, io, sp} = s;
    dn = 0; es = 0; ee = 0;
    if (a) begin
      if (oc == 0) begin
        a = 0;
        if (d && k != 2'd3 && rx < mp) begin dn = 1; es = sp; end
      end else if (oc == 1 || oc == 2) begin
        a = 0; st = 1; ee = 1;
        if (oc == 2) bb = 1;
      end else if (c != 0) begin
        c = c - 1;
        if (c == 0) begin a = 0; st = 1; ee = 1; end
      end
    end
    return {a, st, bb, c, io, sp, dn, io & ~a, es, ee};
  endfunction

  function automatic string tag_of(input logic [6:0] s, input logic [2:0] oc);
    if (!s[6]) return "R10";
    case (oc)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      default: return (s[3:2] == 0) ? "R8" : (s[3:2] == 1) ? "R7" : "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic send(input logic [6:0] s, input logic [1:0] k, input logic d,
      input logic [2:0] oc, input logic [LW-1:0] rx, input logic [LW-1:0] mp, input string tag);
    @(negedge clk);
    td_stat = s; xfer_kind = k; dir_in = d; result_code = oc; rx_len = rx; max_pkt = mp;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, {td_stat_new, set_done, ev_ioc, ev_short, ev_error}, model(s, k, d, oc, rx, mp));
    check(tag, {10'd0, out_valid}, 11'd1);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [6:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset valid", {10'd0, out_valid}, 11'd0);
    check("R11 reset events", {7'd0, set_done, ev_ioc, ev_short, ev_error}, 11'd0);
    rst_n = 1'b1;

    // status layout: active ioc spd; count in bits 3:2
    send(7'b1_0_0_11_1_1, 2'd1, 1'b1, 3'd0, 11'd64, 11'd64, "R2 full success");
    send(7'b1_0_0_10_0_1, 2'd1, 1'b1, 3'd0, 11'd10, 11'd64, "R3 short spd");
    send(7'b1_0_0_10_0_0, 2'd2, 1'b1, 3'd0, 11'd63, 11'd64, "R3 short no spd");
    send(7'b1_0_0_10_0_1, 2'd3, 1'b1, 3'd0, 11'd10, 11'd64, "R3 iso short");
    send(7'b1_0_0_10_0_1, 2'd0, 1'b0, 3'd0, 11'd10, 11'd64, "R3 out short");
    send(7'b1_0_0_10_1_0, 2'd1, 1'b1, 3'd1, 11'd0, 11'd64, "R4 stall");
    send(7'b1_0_0_01_0_0, 2'd1, 1'b1, 3'd2, 11'd0, 11'd64, "R5 babble");
    send(7'b1_0_0_11_1_0, 2'd1, 1'b1, 3'd3, 11'd0, 11'd64, "R6 buffer 3to2");
    send(7'b1_0_0_10_0_0, 2'd1, 1'b1, 3'd4, 11'd0, 11'd64, "R6 stuff 2to1");
    send(7'b1_0_0_01_1_0, 2'd1, 1'b1, 3'd5, 11'd0, 11'd64, "R7 crc exhaust R9");
    send(7'b1_0_0_01_0_0, 2'd1, 1'b1, 3'd7, 11'd0, 11'd64, "R7 reserved exhaust");
    send(7'b1_0_0_00_1_1, 2'd1, 1'b1, 3'd3, 11'd0, 11'd64, "R8 unlimited");
    send(7'b0_1_0_10_1_1, 2'd1, 1'b1, 3'd1, 11'd3, 11'd64, "R10 inactive R9");

    // backpressure
    @(negedge clk);
    check("R11 idle", {6'd0, out_valid, set_done, ev_ioc, ev_short, ev_error}, 11'd0);
    out_ready = 1'b0;
    send(7'b1_0_0_11_1_0, 2'd1, 1'b1, 3'd1, 11'd0, 11'd64, "R1 stalled consumer");
    held = td_stat_new;
    check("R1 ready low", {10'd0, in_ready}, 11'd0);
    td_stat = 7'b1_0_0_11_0_0; result_code = 3'd0; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 hold", {3'd0, td_stat_new, out_valid}, {3'd0, held, 1'b1});
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check("R1 drain", {10'd0, out_valid}, 11'd0);

    for (int i = 0; i < 400; i++) begin
      logic [6:0] s;
      logic [2:0] oc;
      logic [LW-1:0] mp, rx;
      s  = 7'($urandom);
      oc = 3'($urandom);
      mp = LW'($urandom_range(1, 1023));
      case ($urandom_range(0, 2))
        0: rx = mp;
        1: rx = mp - 1;
        default: rx = LW'($urandom_range(0, 1023));
      endcase
      send(s, 2'($urandom), 1'($urandom), oc, rx, mp, tag_of(s, oc));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule